// File: doc/BRIEF.md
# Dual-Clock FIFO with Two Output Timings

This block is a first-in first-out buffer with separate write and read clocks. By default it holds 4096 words of 9 bits. Either clock may run at any rate, or stop, and no ratio between them is required. A word is stored on a rising write-clock edge while `wr_en_n` is low. A word is taken on a rising read-clock edge while `rd_en_n` is low.

The output timing is chosen by the level of `ft_mode` while `mrst_n` is low. That choice holds until the next master reset.

- **Strobed timing (`ft_mode` low):** each word reaches `q` only after a read strobe. `empty_or` reports empty and `full_ir` reports full.
- **Fall-through timing (`ft_mode` high):** the head word reaches `q` without a strobe. `empty_or` then reports output-ready and `full_ir` reports input-ready.

A partial reset clears the contents and keeps the mode. A retransmit strobe rewinds the read side to array location 0 so that stored data can be read again. The half-full, almost-empty and almost-full flags work in both timings. The two almost thresholds come from static inputs.

Top module: `dual_mode_fifo`

## Requirements
- R1: Words written with `wr_en_n` low come out of `q` in the order written. In strobed timing, `q` takes the next word on the read edge where `rd_en_n` is sampled low.
- R2: In strobed timing, `empty_or` is 1 while the FIFO holds no unread word. A word written into an empty FIFO does not reach `q` on its own. `empty_or` falls after the 2nd rising read edge that follows the write edge.
- R3: In strobed timing, `full_ir` is 1 once 4096 unread words are stored. A write while full is ignored and the stored words are unchanged.
- R4: A read while empty is ignored: `q` keeps its value and the read position does not move.
- R5: In fall-through timing, a word written into an empty FIFO is on `q` with `empty_or`=1 after the 3rd rising read edge following the write, with `rd_en_n` high. `full_ir`=1 means there is room for a write.
- R6: In fall-through timing, the word on `q` stays there until a read edge with `rd_en_n` low. That edge replaces it with the next word, or drops `empty_or` to 0 if no word follows.
- R7: `ft_mode` is sampled only while `mrst_n` is low. Its level during a partial reset has no effect.
- R8: While `prst_n` or `mrst_n` is low, both pointers return to location 0 and the FIFO becomes empty.
- R9: `rt_n` sampled low on a rising read edge moves the read position back to location 0. The words written since the reset can then be read again from the first one.
- R10: `half_full` is 1 when more than 2048 words are held, as seen from the write side.
- R11: `almost_empty` is 1 when the unread words, as seen from the read side, are at most `ae_lvl`. `almost_full` is 1 when the words held, as seen from the write side, are at least 4096 minus `af_lvl`.
- R12: After a master reset in strobed timing, `empty_or`=1, `full_ir`=0, `half_full`=0, `almost_empty`=1 and `almost_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, low active, sampled by both clocks |
| prst_n | input | 1 | Partial reset, low active, keeps the mode |
| ft_mode | input | 1 | Timing select, taken during master reset (1 = fall-through) |
| wr_en_n | input | 1 | Write enable, low active |
| d | input | 9 | Write data |
| rd_en_n | input | 1 | Read enable, low active |
| rt_n | input | 1 | Retransmit strobe, low active |
| ae_lvl | input | 12 | Almost-empty threshold |
| af_lvl | input | 12 | Almost-full threshold |
| q | output | 9 | Read data |
| empty_or | output | 1 | Empty (strobed) or output-ready (fall-through) |
| full_ir | output | 1 | Full (strobed) or input-ready (fall-through) |
| half_full | output | 1 | More than half the depth held |
| almost_empty | output | 1 | Read-side fill at or below `ae_lvl` |
| almost_full | output | 1 | Write-side fill at or above depth minus `af_lvl` |

## Verification
Write-side results, namely `full_ir` in strobed timing, `half_full` and `almost_full`, follow the write edge that changes the fill. They are sampled at the next falling write edge. `empty_or` in strobed timing falls two read edges after a write, and the fall-through output word arrives on the third. Those edges are counted one by one with the read clock held stopped during the write, and each is sampled 1 ns after its rising edge. A strobed read word is checked at the falling read edge after the strobed rising edge. Flags that cross domains are checked only after a settling wait of three write and four read cycles.

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DW = 9,
  parameter int AW = 12
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          ft_mode,
  input  logic          wr_en_n,
  input  logic [DW-1:0] d,
  input  logic          rd_en_n,
  input  logic          rt_n,
  input  logic [AW-1:0] ae_lvl,
  input  logic [AW-1:0] af_lvl,
  output logic [DW-1:0] q,
  output logic          empty_or,
  output logic          full_ir,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write side
  logic          w_ft;
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, rq_bin, wfill;
  logic [PW-1:0] rgray;
  logic          w_rst, w_full, do_wr;

  assign w_rst  = !mrst_n || !prst_n;
  assign rq_bin = to_bin(rg_s2);
  assign wfill  = wbin - rq_bin;
  assign w_full = wfill[AW];
  assign do_wr  = !w_rst && !wr_en_n && !w_full;

  always_ff @(posedge wclk) begin
    if (!mrst_n) w_ft <= ft_mode;
    if (w_rst) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (do_wr) begin
        wbin  <= wbin + 1'b1;
        wgray <= to_gray(wbin + 1'b1);
      end
    end
  end

  always_ff @(posedge wclk)
    if (do_wr) mem[wbin[AW-1:0]] <= d;

  assign full_ir     = w_ft ? !w_full : w_full;
  assign half_full   = wfill > PW'(DEPTH / 2);
  assign almost_full = ({1'b0, wfill} + {2'b0, af_lvl}) >= (PW + 1)'(DEPTH);

  // read side
  logic          r_ft, ov;
  logic [PW-1:0] rbin, wg_s1, wg_s2, wq_bin, rfill, rewind;
  logic          r_rst, r_empty, pop_std, pop_ft, pop;

  assign r_rst   = !mrst_n || !prst_n;
  assign wq_bin  = to_bin(wg_s2);
  assign rfill   = wq_bin - rbin;
  assign r_empty = rfill == '0;
  assign rewind  = {wq_bin[AW], {AW{1'b0}}};
  assign pop_std = !r_ft && !rd_en_n && !r_empty;
  assign pop_ft  = r_ft && !r_empty && (!ov || !rd_en_n);
  assign pop     = rt_n && (pop_std || pop_ft);

  always_ff @(posedge rclk) begin
    if (!mrst_n) r_ft <= ft_mode;
    if (r_rst) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      ov    <= 1'b0;
      q     <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (!rt_n) begin
        rbin  <= rewind;
        rgray <= to_gray(rewind);
        ov    <= 1'b0;
      end else begin
        if (pop) begin
          q     <= mem[rbin[AW-1:0]];
          rbin  <= rbin + 1'b1;
          rgray <= to_gray(rbin + 1'b1);
        end
        if (pop_ft) ov <= 1'b1;
        else if (!rd_en_n) ov <= 1'b0;
      end
    end
  end

  assign empty_or     = r_ft ? ov : r_empty;
  assign almost_empty = rfill <= {1'b0, ae_lvl};
endmodule

// File: rtl/fifo_checks.sv
module fifo_checks #(
  parameter int AW = 12
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst_n,
  input logic          prst_n,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic          rt_n,
  input logic          full_ir,
  input logic          half_full,
  input logic          w_ft,
  input logic          r_ft,
  input logic          ov,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [AW:0]   wfill,
  input logic [AW:0]   rfill
);
  localparam int DEPTH = 1 << AW;

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
    (wfill[AW] && !wr_en_n) |=> $stable(wbin));

  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
    (rfill == '0 && rt_n) |=> $stable(rbin));

  p_fill_bound_r3: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
    wfill <= (AW + 1)'(DEPTH));

  p_full_implies_half_r10: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
    (!w_ft && full_ir) |-> half_full);

  p_mode_held_r7: assert property (@(posedge rclk) disable iff (!mrst_n)
    (mrst_n && $past(mrst_n)) |-> $stable(r_ft));

  p_head_held_r6: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
    (r_ft && ov && rd_en_n && rt_n) |=> ov);
endmodule

bind dual_mode_fifo fifo_checks #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
  .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .rt_n(rt_n),
  .full_ir(full_ir), .half_full(half_full), .w_ft(w_ft), .r_ft(r_ft), .ov(ov),
  .wbin(wbin), .rbin(rbin), .wfill(wfill), .rfill(rfill)
);

// File: tb/test_dual_mode_fifo.sv
module test_dual_mode_fifo;
  localparam int DEPTH = 4096;
  localparam logic [8:0] VEC [8] = '{9'h000, 9'h1FF, 9'h0AA, 9'h155,
                                      9'h001, 9'h100, 9'h0F0, 9'h10F};

  logic wclk = 0, rclk = 0, rclk_en = 1;
  logic mrst_n = 0, prst_n = 1, ft_mode = 0, wr_en_n = 1, rd_en_n = 1, rt_n = 1;
  logic [8:0] d = '0;
  logic [11:0] ae_lvl = 12'd4, af_lvl = 12'd4;
  logic [8:0] q;
  logic empty_or, full_ir, half_full, almost_empty, almost_full;
  int errors = 0, checks = 0;

  dual_mode_fifo i_dual_mode_fifo (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .ft_mode(ft_mode),
    .wr_en_n(wr_en_n), .d(d), .rd_en_n(rd_en_n), .rt_n(rt_n),
    .ae_lvl(ae_lvl), .af_lvl(af_lvl), .q(q), .empty_or(empty_or), .full_ir(full_ir),
    .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
  );

  always #5 wclk = ~wclk;
  always begin #8; rclk = rclk_en ? ~rclk : 1'b0; end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mres(input logic m);
    mrst_n = 0; ft_mode = m;
    repeat (3) @(negedge wclk);
    repeat (3) @(negedge rclk);
    mrst_n = 1;
    @(negedge rclk);
  endtask

  task automatic wr(input logic [8:0] v);
    @(negedge wclk); wr_en_n = 0; d = v;
    @(negedge wclk); wr_en_n = 1;
  endtask

  task automatic rd;
    @(negedge rclk); rd_en_n = 0;
    @(negedge rclk); rd_en_n = 1;
  endtask

  task automatic settle;
    repeat (3) @(negedge wclk);
    repeat (4) @(negedge rclk);
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R12 reset state
    mres(0);
    chk("R12 empty", empty_or, 1);
    chk("R12 full", full_ir, 0);
    chk("R12 half", half_full, 0);
    chk("R12 ae", almost_empty, 1);
    chk("R12 af", almost_full, 0);

    // R1 vector table
    for (int i = 0; i < 8; i++) wr(VEC[i]);
    settle;
    for (int i = 0; i < 8; i++) begin
      rd;
      chk("R1 order", q, VEC[i]);
    end
    chk("R2 empty after drain", empty_or, 1);

    // R4 read while empty
    rd;
    chk("R4 q held", q, VEC[7]);
    chk("R4 still empty", empty_or, 1);
    wr(9'h055);
    settle;
    rd;
    chk("R4 pointer unmoved", q, 9'h055);

    // R2 latency in strobed timing
    mres(0);
    @(negedge rclk); rclk_en = 0;
    wr(9'h0C3);
    chk("R2 no auto present", q, 0);
    rclk_en = 1;
    @(posedge rclk); #1;
    chk("R2 edge1 empty", empty_or, 1);
    @(posedge rclk); #1;
    chk("R2 edge2 not empty", empty_or, 0);
    chk("R2 q untouched", q, 0);
    rd;
    chk("R2 read word", q, 9'h0C3);

    // R11 almost empty
    mres(0);
    for (int i = 0; i < 4; i++) wr(9'(i));
    settle;
    chk("R11 ae at level", almost_empty, 1);
    wr(9'h004);
    settle;
    chk("R11 ae above level", almost_empty, 0);

    // R3 R10 R11 fill to full
    mres(0);
    for (int i = 0; i <= DEPTH; i++) begin
      @(negedge wclk);
      if (i == DEPTH / 2)     chk("R10 half at 2048", half_full, 0);
      if (i == DEPTH / 2 + 1) chk("R10 half at 2049", half_full, 1);
      if (i == DEPTH - 5)     chk("R11 af below", almost_full, 0);
      if (i == DEPTH - 4)     chk("R11 af at level", almost_full, 1);
      if (i == DEPTH - 1)     chk("R3 not full", full_ir, 0);
      if (i == DEPTH)         chk("R3 full", full_ir, 1);
      if (i < DEPTH) begin wr_en_n = 0; d = 9'(i) ^ 9'h1A5; end
      else wr_en_n = 1;
    end
    wr(9'h000);
    chk("R3 still full", full_ir, 1);
    settle;
    rd;
    chk("R3 first word kept", q, 9'h1A5);
    rd;
    chk("R3 second word kept", q, 9'h1A4);

    // R5 R6 fall-through
    mres(1);
    chk("R5 not ready", empty_or, 0);
    chk("R5 input ready", full_ir, 1);
    @(negedge rclk); rclk_en = 0;
    wr(9'h13C);
    rclk_en = 1;
    @(posedge rclk); #1;
    chk("R5 edge1", empty_or, 0);
    @(posedge rclk); #1;
    chk("R5 edge2", empty_or, 0);
    @(posedge rclk); #1;
    chk("R5 edge3 ready", empty_or, 1);
    chk("R5 word out", q, 9'h13C);
    wr(9'h021);
    wr(9'h042);
    settle;
    chk("R6 head held", q, 9'h13C);
    rd;
    chk("R6 next word", q, 9'h021);
    rd;
    chk("R6 last word", q, 9'h042);
    rd;
    chk("R6 ready drops", empty_or, 0);

    // R7 R8 partial reset keeps timing
    wr(9'h0AB);
    wr(9'h0CD);
    settle;
    ft_mode = 0; prst_n = 0;
    repeat (3) @(negedge wclk);
    repeat (3) @(negedge rclk);
    prst_n = 1;
    @(negedge rclk);
    chk("R8 emptied", empty_or, 0);
    chk("R7 input ready kept", full_ir, 1);
    wr(9'h077);
    settle;
    chk("R7 falls through", empty_or, 1);
    chk("R7 word", q, 9'h077);

    // R9 retransmit
    mres(0);
    wr(9'h101); wr(9'h102); wr(9'h103);
    settle;
    rd; rd; rd;
    chk("R9 drained", empty_or, 1);
    @(negedge rclk); rt_n = 0;
    @(negedge rclk); rt_n = 1;
    chk("R9 data back", empty_or, 0);
    rd;
    chk("R9 reread first", q, 9'h101);
    rd;
    chk("R9 reread second", q, 9'h102);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule